// File: doc/BRIEF.md
# Vector Bitwise Select Execution Unit

This unit decodes and runs one family of three-operand vector bit-select instructions against its own bank of 32 data registers. A 32-bit instruction word comes in on a valid/ready stream. A side flag tells the unit which of two encodings the word uses: the fixed-width form or the mixed 16/32-bit form. The unit checks every constant bit of the word and builds three 5-bit register indices. It rejects any encoding that is illegal. A legal instruction then merges two source registers into the destination register bit by bit. The destination register is also an operand.

There are three variants, and they differ only in which operand steers each bit. The select-by-destination variant uses the old destination bit as the steering bit. The insert-if-true and insert-if-false variants use the second source, with opposite polarity. A 64-bit instruction touches one register. A 128-bit instruction touches an aligned pair of registers, lower register first. The unit signals completion with a one-cycle `done` pulse, or with a one-cycle `undef` pulse in its place when it rejects the word. The number of cycles depends only on the instruction width, never on register contents.

Back-pressure works as follows. `insn_ready` is high only while the unit is idle. A word is taken on a clock edge where `insn_valid` and `insn_ready` are both high. While `insn_ready` is low, the word and `insn_valid` are ignored and the sender must hold them. A test port reads any register combinationally and writes any register while the unit is idle.

Top module: `bsel_unit`

## Requirements
- R1: The word is accepted only when it matches the constant bits of its encoding, and any mismatch gives `undef` with no register write. The constant bits are:
  - word[31:23] = 111100110 when `insn_mixed`=0, or 111111110 when `insn_mixed`=1;
  - word[11:8] = 0001;
  - word[4] = 1.
- R2: The op field word[21:20] selects the variant: 01 is select-by-destination, 10 is insert-if-true, 11 is insert-if-false. Op 00 gives `undef` and writes nothing.
- R3: The register indices are built as follows, with the single bit as the most significant bit of each:
  - destination = {word[22], word[15:12]};
  - first source = {word[7], word[19:16]};
  - second source = {word[5], word[3:0]};
  - word[6] is the width flag Q.
- R4: Select-by-destination writes (first AND dest) OR (second AND NOT dest).
- R5: Insert-if-true writes (first AND second) OR (dest AND NOT second).
- R6: Insert-if-false writes (dest AND second) OR (first AND NOT second).
- R7: With Q=1 the operation is applied to register index and index+1 of every operand, lower register first. With Q=0 only one register changes.
- R8: With Q=1, a set bit in word[12], word[16] or word[0] gives `undef` and no register changes.
- R9: The result and completion pulses follow fixed timing:
  - `done` rises 2 cycles after acceptance for Q=0 and 3 cycles after for Q=1;
  - `undef` rises 1 cycle after acceptance;
  - each pulse lasts exactly one cycle, and the two are never high together;
  - none of these delays depends on data.
- R10: `insn_ready` is low from acceptance until the cycle after the `done` or `undef` pulse, and a word presented in that time has no effect.
- R11: All operands of a step are read before that step's write. The result is therefore correct when the destination index equals a source index.
- R12: After reset, `insn_ready` is high and `done` and `undef` are low. While idle, `tp_we` writes `tp_wdata` to register `tp_idx`, and `tp_rdata` always shows register `tp_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word is valid |
| insn_ready | output | 1 | Unit can take a word (idle) |
| insn_word | input | 32 | Instruction word |
| insn_mixed | input | 1 | 1: mixed-width encoding, 0: fixed-width encoding |
| done | output | 1 | One-cycle pulse after the last write |
| undef | output | 1 | One-cycle pulse for a rejected word |
| tp_we | input | 1 | Test-port write enable (honoured when idle) |
| tp_idx | input | 5 | Test-port register index |
| tp_wdata | input | REG_W | Test-port write data |
| tp_rdata | output | REG_W | Register `tp_idx` contents |

## Verification
The bench builds the unit with its default register width of 64 bits. At that width every bit lane of a full random pattern is exposed to the steering operand, in both polarities.

Because the register count is fixed at 32 by the 5-bit indices, random indices reach:
- every even/odd pairing case;
- the topmost pair, 30 and 31;
- destination/source aliasing, including all three operands on one register.

Random words of both encodings are mixed with corrupted constant bits and op 00. This brings every rejection path and both latencies within reach.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

  localparam int unsigned NUM_REGS = 32;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);

  localparam logic [8:0] TOP_FIXED = 9'b111100110;
  localparam logic [8:0] TOP_MIXED = 9'b111111110;
  localparam logic [3:0] MID_CONST = 4'b0001;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_BSL  = 2'b01,
    OP_BIT  = 2'b10,
    OP_BIF  = 2'b11
  } bsel_op_e;

  typedef struct packed {
    bsel_op_e         op;
    logic             q;
    logic [IDX_W-1:0] d;
    logic [IDX_W-1:0] n;
    logic [IDX_W-1:0] m;
    logic             legal;
  } bsel_insn_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_STEP0 = 3'd1,
    ST_STEP1 = 3'd2,
    ST_DONE  = 3'd3,
    ST_UNDEF = 3'd4
  } bsel_state_e;

endpackage

// File: rtl/bsel_decode.sv
module bsel_decode
  import bsel_pkg::*;
(
  input  logic [31:0] word,
  input  logic        mixed,
  output bsel_insn_t  dec
);

  logic top_ok, const_ok, op_ok, align_ok;

  always_comb begin
    top_ok   = mixed ? (word[31:23] == TOP_MIXED) : (word[31:23] == TOP_FIXED);
    const_ok = (word[11:8] == MID_CONST) && word[4];
    op_ok    = (word[21:20] != 2'b00);
    align_ok = !word[6] || !(word[12] || word[16] || word[0]);

    dec.op    = bsel_op_e'(word[21:20]);
    dec.q     = word[6];
    dec.d     = {word[22], word[15:12]};
    dec.n     = {word[7],  word[19:16]};
    dec.m     = {word[5],  word[3:0]};
    dec.legal = top_ok && const_ok && op_ok && align_ok;
  end

  // R8: a legal double-width word always names even registers
  always_comb begin
    if (dec.legal && dec.q)
      a_pair_even_r8: assert (!dec.d[0] && !dec.n[0] && !dec.m[0]);
  end

endmodule

// File: rtl/bsel_regfile.sv
module bsel_regfile #(
  parameter int unsigned REG_W    = 64,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [REG_W-1:0] wdata,
  input  logic [IDX_W-1:0] ra_d,
  input  logic [IDX_W-1:0] ra_n,
  input  logic [IDX_W-1:0] ra_m,
  input  logic [IDX_W-1:0] ra_t,
  output logic [REG_W-1:0] rd_d,
  output logic [REG_W-1:0] rd_n,
  output logic [REG_W-1:0] rd_m,
  output logic [REG_W-1:0] rd_t
);

  logic [REG_W-1:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we && (waddr == IDX_W'(g)))
        mem[g] <= wdata;
    end
  end

  // combinational reads: old contents visible during the write cycle (R11)
  assign rd_d = mem[ra_d];
  assign rd_n = mem[ra_n];
  assign rd_m = mem[ra_m];
  assign rd_t = mem[ra_t];

endmodule

// File: rtl/bsel_alu.sv
module bsel_alu
  import bsel_pkg::*;
#(
  parameter int unsigned REG_W = 64
) (
  input  bsel_op_e         op,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src1,
  input  logic [REG_W-1:0] src2,
  output logic [REG_W-1:0] res
);

  always_comb begin
    unique case (op)
      OP_BSL:  res = (src1 & dst)  | (src2 & ~dst);
      OP_BIT:  res = (src1 & src2) | (dst  & ~src2);
      OP_BIF:  res = (dst  & src2) | (src1 & ~src2);
      default: res = dst;
    endcase
  end

endmodule

// File: rtl/bsel_unit.sv
module bsel_unit
  import bsel_pkg::*;
#(
  parameter int unsigned REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_valid,
  output logic             insn_ready,
  input  logic [31:0]      insn_word,
  input  logic             insn_mixed,
  output logic             done,
  output logic             undef,
  input  logic             tp_we,
  input  logic [4:0]       tp_idx,
  input  logic [REG_W-1:0] tp_wdata,
  output logic [REG_W-1:0] tp_rdata
);

  bsel_state_e      state;
  bsel_insn_t       dec, cur;
  logic             accept, step_we, off;
  logic [IDX_W-1:0] ad, an, am, waddr;
  logic [REG_W-1:0] vd, vn, vm, res, wdata;
  logic             we;

  bsel_decode u_dec (
    .word  (insn_word),
    .mixed (insn_mixed),
    .dec   (dec)
  );

  assign insn_ready = (state == ST_IDLE);
  assign accept     = insn_valid && insn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          cur   <= dec;
          state <= dec.legal ? ST_STEP0 : ST_UNDEF;
        end
        ST_STEP0: state <= cur.q ? ST_STEP1 : ST_DONE;
        ST_STEP1: state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign off     = (state == ST_STEP1);
  assign step_we = (state == ST_STEP0) || (state == ST_STEP1);
  assign ad      = cur.d + IDX_W'(off);
  assign an      = cur.n + IDX_W'(off);
  assign am      = cur.m + IDX_W'(off);

  bsel_alu #(.REG_W(REG_W)) u_alu (
    .op   (cur.op),
    .dst  (vd),
    .src1 (vn),
    .src2 (vm),
    .res  (res)
  );

  always_comb begin
    if (step_we) begin
      we    = 1'b1;
      waddr = ad;
      wdata = res;
    end else begin
      we    = tp_we && (state == ST_IDLE);
      waddr = tp_idx;
      wdata = tp_wdata;
    end
  end

  bsel_regfile #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .ra_d  (ad),
    .ra_n  (an),
    .ra_m  (am),
    .ra_t  (tp_idx),
    .rd_d  (vd),
    .rd_n  (vn),
    .rd_m  (vm),
    .rd_t  (tp_rdata)
  );

  assign done  = (state == ST_DONE);
  assign undef = (state == ST_UNDEF);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && undef));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_undef_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dec.legal) |=> undef);

  p_done64_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.legal && !dec.q) |-> ##2 done);

  p_done128_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.legal && dec.q) |-> ##3 done);

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || undef || step_we) |-> !insn_ready);

  p_pair_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STEP1) |-> ($past(we) && waddr == $past(waddr) + IDX_W'(1)));

  p_step_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_we |-> cur.legal);

endmodule

// File: tb/test_bsel_unit.sv
module test_bsel_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic        insn_ready;
  logic [31:0] insn_word = '0;
  logic        insn_mixed = 1'b0;
  logic        done, undef;
  logic        tp_we = 1'b0;
  logic [4:0]  tp_idx = '0;
  logic [63:0] tp_wdata = '0;
  logic [63:0] tp_rdata;

  int compared = 0;
  int mismatched = 0;
  logic [63:0] mdl [32];

  always #2 clk = ~clk;

  bsel_unit #(.REG_W(64)) i_bsel_unit (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn_word(insn_word), .insn_mixed(insn_mixed), .done(done), .undef(undef),
    .tp_we(tp_we), .tp_idx(tp_idx), .tp_wdata(tp_wdata), .tp_rdata(tp_rdata)
  );

  function automatic logic [31:0] enc(input logic mx, input logic [1:0] op,
                                      input logic q, input logic [4:0] d,
                                      input logic [4:0] n, input logic [4:0] m);
    logic [8:0] top;
    top = mx ? 9'b111111110 : 9'b111100110;
    return {top, d[4], op, n[3:0], d[3:0], 4'b0001, n[4], q, m[4], 1'b1, m[3:0]};
  endfunction

  function automatic bit ref_legal(input logic [31:0] w, input logic mx);
    bit ok;
    ok = (w[31:23] == (mx ? 9'b111111110 : 9'b111100110));
    ok = ok && (w[11:8] == 4'b0001) && w[4] && (w[21:20] != 2'b00);
    if (w[6] && (w[12] || w[16] || w[0])) ok = 0;
    return ok;
  endfunction

  function automatic logic [63:0] ref_op(input logic [1:0] op, input logic [63:0] dv,
                                         input logic [63:0] nv, input logic [63:0] mv);
    case (op)
      2'b01:   return (nv & dv) | (mv & ~dv);
      2'b10:   return (nv & mv) | (dv & ~mv);
      default: return (dv & mv) | (nv & ~mv);
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tp_write(input logic [4:0] i, input logic [63:0] v);
    @(negedge clk);
    tp_we = 1'b1; tp_idx = i; tp_wdata = v;
    @(negedge clk);
    tp_we = 1'b0;
    mdl[i] = v;
  endtask

  task automatic tp_read(input logic [4:0] i, output logic [63:0] v);
    tp_idx = i;
    #1;
    v = tp_rdata;
  endtask

  // Runs one word; inject keeps a legal side word presented while busy (R10)
  task automatic run(input logic [31:0] w, input logic mx, input bit inject, input string tag);
    bit legal;
    int lat, cyc;
    logic [4:0] d, n, m;
    logic [63:0] v;
    legal = ref_legal(w, mx);
    d = {w[22], w[15:12]}; n = {w[7], w[19:16]}; m = {w[5], w[3:0]};
    lat = !legal ? 1 : (w[6] ? 3 : 2);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = w; insn_mixed = mx;
    @(negedge clk);
    if (inject) begin
      insn_word = enc(1'b0, 2'b01, 1'b0, 5'd30, 5'd2, 5'd3); insn_mixed = 1'b0;
    end else insn_valid = 1'b0;
    cyc = 1;
    while (!done && !undef && cyc < 20) begin
      if (inject) chk({tag, " R10 ready"}, 64'(insn_ready), 64'd0);
      @(negedge clk);
      cyc++;
    end
    insn_valid = 1'b0;
    chk({tag, " R9 latency"}, 64'(cyc), 64'(lat));
    chk({tag, " R1/R2/R8 kind"}, {62'd0, done, undef}, legal ? 64'd2 : 64'd1);
    @(negedge clk);
    chk({tag, " R9 pulse"}, {62'd0, done, undef}, 64'd0);
    if (legal) begin
      for (int r = 0; r < (w[6] ? 2 : 1); r++)
        mdl[d+5'(r)] = ref_op(w[21:20], mdl[d+5'(r)], mdl[n+5'(r)], mdl[m+5'(r)]);
    end
    tp_read(d, v);
    chk({tag, " R3-dest"}, v, mdl[d]);
    tp_read(d + 5'd1, v);
    chk({tag, " R7 upper"}, v, mdl[d+5'd1]);
    if (inject) begin
      tp_read(5'd30, v);
      chk({tag, " R10 side word"}, v, mdl[30]);
    end
  endtask

  initial begin
    logic [63:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R12 reset ready", 64'(insn_ready), 64'd1);
    chk("R12 reset pulses", {62'd0, done, undef}, 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) tp_write(5'(i), {$urandom, $urandom});
    tp_read(5'd7, v);
    chk("R12 test port", v, mdl[7]);

    tp_write(5'd4, 64'hFF00_FF00_0F0F_3C3C);
    tp_write(5'd5, 64'hAAAA_AAAA_AAAA_AAAA);
    tp_write(5'd6, 64'h5555_0000_FFFF_1234);
    run(enc(0, 2'b01, 0, 5'd4, 5'd5, 5'd6), 0, 0, "R4 BSL");
    tp_write(5'd4, 64'hFF00_FF00_0F0F_3C3C);
    run(enc(0, 2'b10, 0, 5'd4, 5'd5, 5'd6), 0, 0, "R5 BIT");
    tp_write(5'd4, 64'hFF00_FF00_0F0F_3C3C);
    run(enc(1, 2'b11, 0, 5'd4, 5'd5, 5'd6), 1, 0, "R6 BIF mixed");
    run(enc(0, 2'b01, 0, 5'd9, 5'd9, 5'd9), 0, 0, "R11 alias all");
    run(enc(0, 2'b10, 0, 5'd17, 5'd3, 5'd17), 0, 0, "R11 alias d=m");
    run(enc(0, 2'b01, 1, 5'd30, 5'd0, 5'd14), 0, 0, "R7 top pair");
    run(enc(1, 2'b11, 1, 5'd8, 5'd8, 5'd20), 1, 0, "R7 pair alias");
    run(enc(0, 2'b01, 1, 5'd8, 5'd3, 5'd4), 0, 0, "R8 odd n");
    run(enc(0, 2'b10, 1, 5'd8, 5'd2, 5'd5), 0, 0, "R8 odd m");
    run(enc(0, 2'b00, 0, 5'd8, 5'd2, 5'd4), 0, 0, "R2 op00");
    run(enc(1, 2'b01, 0, 5'd8, 5'd2, 5'd4), 0, 0, "R1 wrong form");
    run(enc(0, 2'b01, 0, 5'd8, 5'd2, 5'd4) ^ 32'h0000_0100, 0, 0, "R1 mid bits");
    run(enc(0, 2'b01, 0, 5'd8, 5'd2, 5'd4) ^ 32'h0000_0010, 0, 0, "R1 bit4");
    run(enc(0, 2'b10, 1, 5'd10, 5'd12, 5'd14), 0, 1, "R10 busy");

    for (int k = 0; k < 300; k++) begin
      logic mx; logic [31:0] w;
      mx = 1'($urandom);
      w = enc(mx, 2'($urandom), 1'($urandom % 3 == 0), 5'($urandom), 5'($urandom), 5'($urandom));
      if ($urandom % 10 == 0) w = w ^ (32'd1 << ($urandom % 32));
      run(w, mx, 0, "rand");
    end

    for (int i = 0; i < 32; i++) begin
      tp_read(5'(i), v);
      chk("R12 final sweep", v, mdl[i]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule